// File: doc/BRIEF.md
# SPI FIFO Slot Packer

This block sits between byte-wide streams and the 32-bit slots of an SPI master's transmit and receive FIFOs. A transfer is started with a word size of 1, 2 or 4 bytes, a slot count, and separate byte lengths for the transmit and receive streams. The block first fills up to the slot count of output FIFO slots, taking bytes from a valid/ready source and placing them left-justified from bit 31. When the source length is used up it still writes zero-filled slots, so that the shifter keeps clocking and reply data can be fetched. It then pops up to the same number of input FIFO slots and returns their bytes in wire order on a valid/ready sink. Bytes beyond the receive length are discarded.

Either phase ends early when the output FIFO is full at a slot boundary, or when the input FIFO is empty. A one-cycle done pulse closes the transfer. A combinational helper converts the configured word size into the bits-per-word field. It also proposes a word size and slot count for a given number of remaining bytes.

Top module: `spi_slot_packer`

## Requirements
- R1: Word-size select `cfgWordSel` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Transmit byte k of a slot (k = 0 first) lands in bits [31-8k : 24-8k]. With 1-byte words only 31:24 is filled and with 2-byte words only 31:16; all other bits are zero.
- R2: With 4-byte words, source bytes aa, bb, cc, dd produce the slot 0xaabbccdd.
- R3: Every counted slot is written unless the output FIFO is full. Slot bytes with no source byte left are zero. No source byte is requested past `cfgTxLen`.
- R4: Receive extraction order is: 1-byte words give bits 7:0; 2-byte words give 15:8 then 7:0; 4-byte words give 31:24, 23:16, 15:8, then 7:0.
- R5: Received bytes beyond `cfgRxLen` are dropped without appearing on the sink. Slots are still popped until the count is reached.
- R6: When `outFull` is high at a slot boundary, the transmit phase ends. No further slot is written and no source byte is consumed for it.
- R7: When `inNotEmpty` is low at a slot boundary, the receive phase ends, and no pop is issued while it is low.
- R8: `done` pulses for exactly one cycle after both phases. `busy` is high from the cycle after `start` until `done`. A `start` during a transfer is ignored.
- R9: `bitsPerWord` equals bytes*8-1 for `cfgWordSel`: 7, 15 or 31.
- R10: `planWordSel` is 2 (4-byte) when `planRemain` is a nonzero multiple of 4, otherwise 0 (1-byte).
- R11: `planSlots` is the lesser of `planRemain` divided by the planned word size and `FIFO_WORDS`.
- R12: A presented receive byte holds valid and stable until accepted. No FIFO strobe or stream handshake is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| cfgWordSel | input | 2 | Transfer word size select |
| cfgSlots | input | CNT_W | FIFO slots to move per phase |
| cfgTxLen | input | LEN_W | Source bytes available |
| cfgRxLen | input | LEN_W | Sink bytes wanted |
| bitsPerWord | output | 5 | Bits-per-word field for cfgWordSel |
| planRemain | input | LEN_W | Remaining bytes for the planner |
| planWordSel | output | 2 | Proposed word size select |
| planSlots | output | CNT_W | Proposed slot count |
| txByteValid | input | 1 | Source byte valid |
| txByte | input | 8 | Source byte |
| txByteReady | output | 1 | Source byte accepted |
| outFull | input | 1 | Output FIFO full |
| outWrite | output | 1 | Output FIFO write strobe |
| outData | output | 32 | Output FIFO slot data |
| inNotEmpty | input | 1 | Input FIFO holds data |
| inData | input | 32 | Input FIFO head slot |
| inPop | output | 1 | Input FIFO pop strobe |
| rxByteValid | output | 1 | Sink byte valid |
| rxByte | output | 8 | Sink byte |
| rxByteReady | input | 1 | Sink accepts byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the phantom tail, where the source runs dry mid-slot. A design that stalls there would hang, and one that stops writing would leave slots missing. It targets the receive tail past the sink length, where a wrong design would leak extra bytes or stop popping. The output-full and input-empty stops are checked against leftover source and FIFO contents, which exposes any byte consumed for an unwritten slot. Lane order is checked for each word size, where a reversed or misaligned lane shows up as a byte mismatch. A second start while busy is also tested, which would corrupt the scoreboard stream if honoured.

// File: rtl/spi_slot_pkg.sv
package spi_slot_pkg;
  localparam int SLOT_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_TXCHECK, S_TXGATHER, S_TXWRITE, S_RXCHECK, S_RXEMIT, S_DONE
  } slot_state_t;

  typedef struct packed {
    logic       txClear;
    logic       txLoad;
    logic       rxCapture;
    logic [1:0] idx;
    logic [2:0] nBytes;
  } slot_strobe_t;

  function automatic logic [2:0] bytesOf(input logic [1:0] sel);
    case (sel)
      2'd0:    bytesOf = 3'd1;
      2'd1:    bytesOf = 3'd2;
      default: bytesOf = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/slot_planner.sv
module slot_planner import spi_slot_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 16,
  parameter int FIFO_WORDS = 16
) (
  input  logic [1:0]       cfgWordSel,
  input  logic [LEN_W-1:0] planRemain,
  output logic [4:0]       bitsPerWord,
  output logic [1:0]       planWordSel,
  output logic [CNT_W-1:0] planSlots
);
  localparam logic [LEN_W-1:0] FIFO_LIM = LEN_W'(FIFO_WORDS);

  logic [5:0]       bitsWide;
  logic             useWord;
  logic [LEN_W-1:0] quot;

  always_comb begin
    bitsWide    = {bytesOf(cfgWordSel), 3'b000} - 6'd1;
    bitsPerWord = bitsWide[4:0];
    useWord     = (planRemain != '0) && (planRemain[1:0] == 2'b00);
    planWordSel = useWord ? 2'd2 : 2'd0;
    quot        = useWord ? (planRemain >> 2) : planRemain;
    planSlots   = (quot > FIFO_LIM) ? CNT_W'(FIFO_LIM) : CNT_W'(quot);
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl import spi_slot_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cfgWordSel,
  input  logic [CNT_W-1:0] cfgSlots,
  input  logic [LEN_W-1:0] cfgTxLen,
  input  logic [LEN_W-1:0] cfgRxLen,
  input  logic             outFull,
  input  logic             inNotEmpty,
  input  logic             txByteValid,
  input  logic             rxByteReady,
  output logic             txByteReady,
  output logic             rxByteValid,
  output logic             outWrite,
  output logic             inPop,
  output logic             busy,
  output logic             done,
  output slot_strobe_t     stb
);
  slot_state_t      state;
  logic [2:0]       wbReg;
  logic [CNT_W-1:0] cntReg, slotsLeft;
  logic [LEN_W-1:0] txLeft, rxLeft;
  logic [1:0]       idx;
  logic             lastByte, txStep, rxStep;

  always_comb begin
    lastByte    = ({1'b0, idx} == (wbReg - 3'd1));
    txByteReady = (state == S_TXGATHER) && (txLeft != '0);
    rxByteValid = (state == S_RXEMIT) && (rxLeft != '0);
    outWrite    = (state == S_TXWRITE);
    inPop       = (state == S_RXCHECK) && (slotsLeft != '0) && inNotEmpty;
    done        = (state == S_DONE);
    busy        = (state != S_IDLE);
    txStep      = (state == S_TXGATHER) && ((txLeft == '0) || txByteValid);
    rxStep      = (state == S_RXEMIT) && ((rxLeft == '0) || rxByteReady);
    stb.txClear   = (state == S_TXCHECK);
    stb.txLoad    = txStep && (txLeft != '0);
    stb.rxCapture = inPop;
    stb.idx       = idx;
    stb.nBytes    = wbReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wbReg     <= 3'd1;
      cntReg    <= '0;
      slotsLeft <= '0;
      txLeft    <= '0;
      rxLeft    <= '0;
      idx       <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          wbReg     <= bytesOf(cfgWordSel);
          cntReg    <= cfgSlots;
          slotsLeft <= cfgSlots;
          txLeft    <= cfgTxLen;
          rxLeft    <= cfgRxLen;
          state     <= S_TXCHECK;
        end
        S_TXCHECK: begin
          if ((slotsLeft == '0) || outFull) begin
            slotsLeft <= cntReg;
            state     <= S_RXCHECK;
          end else begin
            idx   <= '0;
            state <= S_TXGATHER;
          end
        end
        S_TXGATHER: if (txStep) begin
          if (txLeft != '0) txLeft <= txLeft - 1'b1;
          if (lastByte) state <= S_TXWRITE;
          else          idx   <= idx + 2'd1;
        end
        S_TXWRITE: begin
          slotsLeft <= slotsLeft - 1'b1;
          state     <= S_TXCHECK;
        end
        S_RXCHECK: begin
          if (inPop) begin
            idx   <= '0;
            state <= S_RXEMIT;
          end else begin
            state <= S_DONE;
          end
        end
        S_RXEMIT: if (rxStep) begin
          if (rxLeft != '0) rxLeft <= rxLeft - 1'b1;
          if (lastByte) begin
            slotsLeft <= slotsLeft - 1'b1;
            state     <= S_RXCHECK;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_datapath.sv
module slot_datapath import spi_slot_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  slot_strobe_t      stb,
  input  logic [7:0]        txByte,
  input  logic [SLOT_W-1:0] inData,
  output logic [SLOT_W-1:0] outData,
  output logic [7:0]        rxByte
);
  logic [SLOT_W-1:0] txWord, rxWord;
  logic [4:0]        txBase;
  logic [5:0]        rxShift;
  logic [2:0]        rxLane;

  always_comb begin
    txBase  = {2'd3 - stb.idx, 3'b000};
    rxLane  = stb.nBytes - 3'd1 - {1'b0, stb.idx};
    rxShift = {rxLane, 3'b000};
    outData = txWord;
    rxByte  = 8'(rxWord >> rxShift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord <= '0;
      rxWord <= '0;
    end else begin
      if (stb.txClear)   txWord <= '0;
      if (stb.txLoad)    txWord[txBase +: 8] <= txByte;
      if (stb.rxCapture) rxWord <= inData;
    end
  end
endmodule

// File: rtl/spi_slot_packer.sv
module spi_slot_packer import spi_slot_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 16,
  parameter int FIFO_WORDS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cfgWordSel,
  input  logic [CNT_W-1:0] cfgSlots,
  input  logic [LEN_W-1:0] cfgTxLen,
  input  logic [LEN_W-1:0] cfgRxLen,
  output logic [4:0]       bitsPerWord,
  input  logic [LEN_W-1:0] planRemain,
  output logic [1:0]       planWordSel,
  output logic [CNT_W-1:0] planSlots,
  input  logic             txByteValid,
  input  logic [7:0]       txByte,
  output logic             txByteReady,
  input  logic             outFull,
  output logic             outWrite,
  output logic [31:0]      outData,
  input  logic             inNotEmpty,
  input  logic [31:0]      inData,
  output logic             inPop,
  output logic             rxByteValid,
  output logic [7:0]       rxByte,
  input  logic             rxByteReady,
  output logic             busy,
  output logic             done
);
  slot_strobe_t stb;

  slot_planner #(.CNT_W(CNT_W), .LEN_W(LEN_W), .FIFO_WORDS(FIFO_WORDS)) u_plan (
    .cfgWordSel(cfgWordSel), .planRemain(planRemain), .bitsPerWord(bitsPerWord),
    .planWordSel(planWordSel), .planSlots(planSlots)
  );

  slot_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWordSel(cfgWordSel),
    .cfgSlots(cfgSlots), .cfgTxLen(cfgTxLen), .cfgRxLen(cfgRxLen),
    .outFull(outFull), .inNotEmpty(inNotEmpty), .txByteValid(txByteValid),
    .rxByteReady(rxByteReady), .txByteReady(txByteReady), .rxByteValid(rxByteValid),
    .outWrite(outWrite), .inPop(inPop), .busy(busy), .done(done), .stb(stb)
  );

  slot_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(txByte), .inData(inData),
    .outData(outData), .rxByte(rxByte)
  );
endmodule

// File: rtl/slot_packer_chk.sv
module slot_packer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       outWrite,
  input logic       inPop,
  input logic       inNotEmpty,
  input logic       txByteReady,
  input logic       rxByteValid,
  input logic       rxByteReady,
  input logic [7:0] rxByte
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(outWrite || inPop || txByteReady || rxByteValid));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R7
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    inPop |-> inNotEmpty);
  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && !rxByteReady) |=> (rxByteValid && $stable(rxByte)));
  // R3
  write_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |=> !outWrite);
endmodule

bind spi_slot_packer slot_packer_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .outWrite(outWrite),
  .inPop(inPop), .inNotEmpty(inNotEmpty), .txByteReady(txByteReady),
  .rxByteValid(rxByteValid), .rxByteReady(rxByteReady), .rxByte(rxByte)
);

// File: tb/test_spi_slot_packer.sv
module test_spi_slot_packer;
  localparam int CNT_W = 8;
  localparam int LEN_W = 16;
  localparam int FIFO_WORDS = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, txByteValid, txByteReady, outFull, outWrite, inNotEmpty, inPop;
  logic rxByteValid, rxByteReady, busy, done;
  logic [1:0] cfgWordSel, planWordSel;
  logic [CNT_W-1:0] cfgSlots, planSlots;
  logic [LEN_W-1:0] cfgTxLen, cfgRxLen, planRemain;
  logic [4:0] bitsPerWord;
  logic [7:0] txByte, rxByte;
  logic [31:0] outData, inData;

  spi_slot_packer #(.CNT_W(CNT_W), .LEN_W(LEN_W), .FIFO_WORDS(FIFO_WORDS)) i_spi_slot_packer (
    .clk(clk), .rstN(rstN), .start(start), .cfgWordSel(cfgWordSel), .cfgSlots(cfgSlots),
    .cfgTxLen(cfgTxLen), .cfgRxLen(cfgRxLen), .bitsPerWord(bitsPerWord),
    .planRemain(planRemain), .planWordSel(planWordSel), .planSlots(planSlots),
    .txByteValid(txByteValid), .txByte(txByte), .txByteReady(txByteReady),
    .outFull(outFull), .outWrite(outWrite), .outData(outData),
    .inNotEmpty(inNotEmpty), .inData(inData), .inPop(inPop),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxByteReady(rxByteReady),
    .busy(busy), .done(done)
  );

  int nChk = 0, nBad = 0, cyc = 0, outCount = 0, outRoom = 64;
  bit stallTx = 0, throttleRx = 0, finished = 0;
  string curTag = "R0";
  logic [7:0]  txQ[$];
  logic [31:0] inQ[$];
  logic [31:0] expOut[$];
  logic [7:0]  expRx[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare at negedge, update FIFO/stream models after the edge
  logic mW, mP, mRv, mTk;
  logic [31:0] mD;
  logic [7:0]  mB;
  always begin
    @(negedge clk);
    mW = outWrite; mD = outData; mP = inPop;
    mRv = rxByteValid && rxByteReady; mB = rxByte;
    mTk = txByteValid && txByteReady;
    if (mW) begin
      if (expOut.size() == 0) check({curTag, " unexpected slot"}, mD, 32'hFFFF_FFFF);
      else check({curTag, " slot"}, mD, expOut.pop_front());
    end
    if (mRv) begin
      if (expRx.size() == 0) check({curTag, " unexpected rx byte"}, 32'(mB), 32'h1FF);
      else check({curTag, " rx byte"}, 32'(mB), 32'(expRx.pop_front()));
    end
    @(posedge clk);
    #1;
    if (mP && inQ.size() > 0) void'(inQ.pop_front());
    if (mW) outCount++;
    if (mTk && txQ.size() > 0) void'(txQ.pop_front());
    cyc++;
    inNotEmpty  = (inQ.size() > 0);
    inData      = (inQ.size() > 0) ? inQ[0] : 32'h0;
    outFull     = (outCount >= outRoom);
    txByteValid = (txQ.size() > 0) && !(stallTx && cyc[0]);
    txByte      = (txQ.size() > 0) ? txQ[0] : 8'h0;
    rxByteReady = !(throttleRx && (cyc % 3 == 0));
  end

  task automatic runXfer(input int sel, input int cnt, input int txLen, input int rxLen,
                         input int room, input bit glitch, input string tag);
    int wb, written, consumed, pops, taken, remTx, remIn, dones;
    logic [31:0] w;
    wb = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
    written = (cnt < room) ? cnt : room;
    for (int s = 0; s < written; s++) begin
      w = 32'h0;
      for (int k = 0; k < wb; k++)
        if (s * wb + k < txLen) w = w | (32'(txQ[s * wb + k]) << (24 - 8 * k));
      expOut.push_back(w);
    end
    consumed = (txLen < written * wb) ? txLen : written * wb;
    pops = (cnt < inQ.size()) ? cnt : inQ.size();
    taken = 0;
    for (int j = 0; j < pops; j++)
      for (int k = 0; k < wb; k++)
        if (taken < rxLen) begin
          expRx.push_back(8'(inQ[j] >> (8 * (wb - 1 - k))));
          taken++;
        end
    remTx = txQ.size() - consumed;
    remIn = inQ.size() - pops;
    curTag = tag;
    outCount = 0;
    outRoom = room;
    @(negedge clk);
    cfgWordSel = 2'(sel); cfgSlots = CNT_W'(cnt);
    cfgTxLen = LEN_W'(txLen); cfgRxLen = LEN_W'(rxLen);
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    @(negedge clk);
    check({tag, " R8 busy after start"}, 32'(busy), 32'd1);
    if (glitch) begin
      repeat (3) @(negedge clk);
      cfgWordSel = 2'd2; cfgSlots = 8'd1; cfgTxLen = 16'd0; cfgRxLen = 16'd0;
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    while (!done) @(negedge clk);
    dones = 1;
    @(negedge clk);
    if (done) dones++;
    check({tag, " R8 single done pulse"}, 32'(dones), 32'd1);
    check({tag, " R8 idle after done"}, 32'(busy), 32'd0);
    @(posedge clk); #2;
    check({tag, " R3 R6 slots left unwritten"}, 32'(expOut.size()), 32'd0);
    check({tag, " R5 R7 rx bytes left"}, 32'(expRx.size()), 32'd0);
    check({tag, " R6 source bytes left"}, 32'(txQ.size()), 32'(remTx));
    check({tag, " R7 input slots left"}, 32'(inQ.size()), 32'(remIn));
    if (glitch) begin
      repeat (6) @(negedge clk);
      check({tag, " R8 second start ignored"}, 32'(busy), 32'd0);
    end
  endtask

  task automatic planCheck(input int remain, input int eSel, input int eSlots);
    planRemain = LEN_W'(remain);
    #1;
    check("R10 plan word size", 32'(planWordSel), 32'(eSel));
    check("R11 plan slot count", 32'(planSlots), 32'(eSlots));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired in %s", curTag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; cfgWordSel = 2'd0; cfgSlots = '0;
    cfgTxLen = '0; cfgRxLen = '0; planRemain = '0;
    txByteValid = 1'b0; txByte = 8'h0; outFull = 1'b0;
    inNotEmpty = 1'b0; inData = 32'h0; rxByteReady = 1'b1;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check("R12 reset busy", 32'(busy), 32'd0);
    check("R12 reset done", 32'(done), 32'd0);
    check("R12 reset strobes", 32'({outWrite, inPop, txByteReady, rxByteValid}), 32'd0);

    // R9 bits-per-word field
    cfgWordSel = 2'd0; #1 check("R9 bits 1-byte", 32'(bitsPerWord), 32'd7);
    cfgWordSel = 2'd1; #1 check("R9 bits 2-byte", 32'(bitsPerWord), 32'd15);
    cfgWordSel = 2'd2; #1 check("R9 bits 4-byte", 32'(bitsPerWord), 32'd31);

    // R10 R11 planner
    planCheck(0, 0, 0);
    planCheck(12, 2, 3);
    planCheck(7, 0, 7);
    planCheck(100, 2, 16);
    planCheck(30, 0, 16);

    // R2 R4: 4-byte words, full lengths
    txQ = '{8'haa, 8'hbb, 8'hcc, 8'hdd, 8'h11, 8'h22, 8'h33, 8'h44};
    inQ = '{32'hA1B2C3D4, 32'h55667788};
    runXfer(2, 2, 8, 8, 64, 0, "R2_R4_word");

    // R1 R4: 1-byte words
    txQ = '{8'h5a, 8'h3c, 8'hf0};
    inQ = '{32'hDEAD0012, 32'hBEEF0034, 32'hCAFE0056};
    runXfer(0, 3, 3, 3, 64, 0, "R1_R4_byte");

    // R1 R3 R5: 2-byte words, phantom tail and dropped rx tail
    txQ = '{8'h12, 8'h34, 8'h56};
    inQ = '{32'h0000A1A2, 32'h0000B1B2, 32'h0000C1C2};
    runXfer(1, 3, 3, 3, 64, 0, "R1_R3_R5_half");

    // R6 R7: output fills after 2 slots, input holds 1 slot
    txQ = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
            8'h09, 8'h0a, 8'h0b, 8'h0c, 8'h0d, 8'h0e, 8'h0f, 8'h10};
    inQ = '{32'h90807060};
    runXfer(2, 4, 16, 16, 2, 0, "R6_R7_stop");
    txQ.delete();
    inQ.delete();

    // R8 R12: stalled source, throttled sink, start pulsed mid-transfer
    stallTx = 1; throttleRx = 1;
    txQ = '{8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86};
    inQ = '{32'h11, 32'h22, 32'h33, 32'h44, 32'h55, 32'h66};
    runXfer(0, 6, 6, 6, 64, 1, "R8_R12_stall");
    stallTx = 0; throttleRx = 0;

    // R3: no source bytes at all, every slot phantom zero
    inQ = '{32'h01020304};
    runXfer(2, 2, 0, 4, 64, 0, "R3_phantom_all");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule